// File: doc/BRIEF.md
# Programmable LED Flasher

This block drives one indicator pin in a repeating on/off pattern. It runs from a 32.768 kHz real-time clock and needs no processor work once it is set up. A single configuration word holds an enable bit, a period select and a mark length. The period is chosen in whole seconds, from one to four. The on-time is chosen in sixteenths of that period, and a full sixteen-sixteenths setting holds the pin high all the time.

A prescaler splits each period into sixteen equal slots, and a slot counter steps through them. The pin is high for the first slots of each cycle, up to the programmed mark, and low for the rest. A new configuration word is held in a shadow register and copied in only at the end of a period, so a cycle that is already running always finishes with the old settings. Clearing the enable bit is the one exception: it stops the output at once. The configuration port is a plain write strobe with data, with no handshake.

Top module: `led_flasher`

## Requirements
- R1: After reset the output is low. It stays low, and the flasher stays idle, until a configuration with the enable bit set is written.
- R2: One sixteenth of a period lasts (k+1)*SIXT_BASE clock cycles, where k is the value of the period select. A full period is sixteen sixteenths. With SIXT_BASE = 2048 at 32.768 kHz this gives periods of k+1 seconds.
- R3: The mark field m (4 bits) encodes m+1 sixteenths. The output is high for the first (m+1)*(k+1)*SIXT_BASE cycles of each period and low for the rest of that period.
- R4: With m = 15 the output stays high without a break across period boundaries.
- R5: A write while the flasher is enabled and running leaves the current period unchanged. The new period select and mark take effect from the first cycle of the next period.
- R6: A write with the enable bit clear forces the output low from the next clock edge. The output stays low until an enabling write arrives.
- R7: An enabling write while the flasher is idle starts a new period at the next clock edge, with the output high in its first cycle.
- R8: Field encodings are as follows. cfg_period value k selects a period of (k+1) units. cfg_mark value m selects m+1 sixteenths. cfg_en = 1 enables the flasher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz real-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_en | input | 1 | Enable bit of the written word |
| cfg_period | input | 2 | Period select k; the period is (k+1) seconds |
| cfg_mark | input | 4 | Mark length m; the output is high for m+1 sixteenths |
| led_out | output | 1 | Flasher output pin |

## Verification
The bench builds the block with SIXT_BASE = 4 instead of 2048, so one sixteenth lasts 4 to 16 cycles and a period lasts 64 to 256 cycles. With that setting, every period select and a spread of mark values can be followed over two full periods each, cycle by cycle, within a short run. The same setting brings mid-period rewrites, immediate disable and the boundary hand-over from one period to the next within a few hundred cycles.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int PER_W  = 2;
  localparam int MARK_W = 4;

  typedef struct packed {
    logic              en;
    logic [PER_W-1:0]  per;
    logic [MARK_W-1:0] mark;
  } lf_cfg_t;
endpackage

// File: rtl/lf_cfg_reg.sv
module lf_cfg_reg
  import lf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  lf_cfg_t wr_cfg,
  input  logic    wrap,
  output lf_cfg_t act,
  output logic    kill
);
  lf_cfg_t pend_q, pend_d, act_q;

  assign pend_d = wr ? wr_cfg : pend_q;
  assign kill   = wr && !wr_cfg.en;
  assign act    = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (kill)
        act_q <= '0;
      else if (!act_q.en || wrap)
        act_q <= pend_d;
    end
  end

  // Running settings only change at a period boundary or on disable.
  assert_hold_mid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.en && !wrap && !kill) |=> $stable(act_q));
endmodule

// File: rtl/lf_prescaler.sv
module lf_prescaler
  import lf_pkg::*;
#(
  parameter int SIXT_BASE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PER_W-1:0]  per,
  output logic [MARK_W-1:0] phase,
  output logic              wrap
);
  localparam int PER_MAX = 1 << PER_W;
  localparam int LEN_MAX = PER_MAX * SIXT_BASE;
  localparam int CW      = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;
  localparam int LW      = CW + 1;
  localparam int PHASES  = 1 << MARK_W;

  logic [CW-1:0]     cnt_q;
  logic [MARK_W-1:0] phase_q;
  logic [LW-1:0]     len;
  logic              tick;

  assign len   = LW'(per) * LW'(SIXT_BASE) + LW'(SIXT_BASE);
  assign tick  = run && ({1'b0, cnt_q} == len - LW'(1));
  assign wrap  = tick && (phase_q == MARK_W'(PHASES - 1));
  assign phase = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= phase_q + MARK_W'(1);
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, cnt_q} < len));
  assert_phase_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/lf_compare.sv
module lf_compare
  import lf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MARK_W-1:0] mark,
  input  logic [MARK_W-1:0] phase,
  output logic              led
);
  assign led = en && (phase <= mark);

  assert_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led) |-> (phase == '0));
  assert_fall_after_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led) |-> (!en || ({1'b0, phase} == ({1'b0, mark} + (MARK_W+1)'(1)))));
endmodule

// File: rtl/led_flasher.sv
module led_flasher
  import lf_pkg::*;
#(
  parameter int SIXT_BASE = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [MARK_W-1:0] cfg_mark,
  output logic              led_out
);
  lf_cfg_t           wr_cfg, act;
  logic              wrap, kill;
  logic [MARK_W-1:0] phase;

  assign wr_cfg = '{en: cfg_en, per: cfg_period, mark: cfg_mark};

  lf_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_cfg(wr_cfg),
    .wrap(wrap), .act(act), .kill(kill)
  );

  lf_prescaler #(.SIXT_BASE(SIXT_BASE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(act.en), .per(act.per),
    .phase(phase), .wrap(wrap)
  );

  lf_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .en(act.en), .mark(act.mark),
    .phase(phase), .led(led_out)
  );

  assert_off_after_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_en) |=> !led_out);
  assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_en && !act.en) |=> led_out);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act.en |-> !led_out);
endmodule

// File: tb/sim_led_flasher.sv
`timescale 1ns/1ps
module sim_led_flasher;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_en = 1'b0;
  logic [1:0] cfg_period = '0;
  logic [3:0] cfg_mark = '0;
  logic       led_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  led_flasher #(.SIXT_BASE(B)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_period(cfg_period), .cfg_mark(cfg_mark), .led_out(led_out)
  );

  // {period k, mark m, sixteenths high = m+1}; covers R8 encodings
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 4'd0,  5'd1},
    {2'd0, 4'd7,  5'd8},
    {2'd1, 4'd3,  5'd4},
    {2'd2, 4'd15, 5'd16},
    {2'd3, 4'd12, 5'd13},
    {2'd3, 4'd0,  5'd1},
    {2'd1, 4'd14, 5'd15},
    {2'd2, 4'd5,  5'd6}
  };

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // Drive one write at a negedge; returns at the next negedge with the
  // strobe released, where the first result of the write is visible.
  task automatic wr(input bit en, input int per, input int mark);
    cfg_wr = 1'b1; cfg_en = en; cfg_period = 2'(per); cfg_mark = 4'(mark);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(led_out == 1'b0, "R1 reset", led_out, 0);
    rst_n = 1'b1;
    bad = 0;
    repeat (50) begin @(negedge clk); if (led_out) bad++; end
    check(bad == 0, "R1 idle low", bad, 0);

    // Vector table: R2, R3, R4, R8 over two full periods plus one cycle
    foreach (VEC[v]) begin
      int per, mark, hi, len, p;
      per  = int'(VEC[v][10:9]);
      mark = int'(VEC[v][8:5]);
      hi   = int'(VEC[v][4:0]);
      len  = (per + 1) * B;
      p    = 16 * len;
      wr(1'b0, 0, 0);
      wr(1'b1, per, mark);
      bad = 0;
      for (int i = 0; i <= 2 * p; i++) begin
        bit e;
        e = ((i % p) < hi * len);
        if (led_out !== e) bad++;
        @(negedge clk);
      end
      check(bad == 0, (mark == 15) ? "R4 held high" : "R2/R3 pattern", bad, 0);
    end

    // R7: enabling from idle gives high in first cycle
    wr(1'b0, 0, 0);
    @(negedge clk);
    wr(1'b1, 3, 0);
    check(led_out == 1'b1, "R7 start high", led_out, 1);

    // R6: disable mid-high forces low next edge and holds it
    repeat (5) @(negedge clk);
    check(led_out == 1'b1, "R6 pre-disable high", led_out, 1);
    wr(1'b0, 3, 15);
    check(led_out == 1'b0, "R6 immediate low", led_out, 0);
    bad = 0;
    repeat (300) begin @(negedge clk); if (led_out) bad++; end
    check(bad == 0, "R6 stays low", bad, 0);

    // R5: rewrite mid-period; old settings finish the cycle
    wr(1'b1, 0, 3);
    bad = 0;
    for (int i = 0; i <= 64 + 128; i++) begin
      bit e;
      if (i < 64) e = (i < 16);
      else        e = ((i - 64) % 128) < 88;
      if (led_out !== e) bad++;
      if (i == 10) begin
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_period = 2'd1; cfg_mark = 4'd10;
      end
      if (i == 11) cfg_wr = 1'b0;
      @(negedge clk);
    end
    check(bad == 0, "R5 boundary hand-over", bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule